// File: doc/BRIEF.md
# BCD Clock Calendar Counter

This block holds wall-clock time and calendar date as seven BCD fields: seconds, minutes, hours (24-hour), day of week, day of month, month and two-digit year. It advances by one second on each cycle in which the one-second strobe from an upstream divider is high. The carry ripples through the fields in the same clock cycle. Month lengths and leap years are taken into account. A century flag can be made to flip when the year wraps.

A host interface writes any field directly, one byte at a time, and reads any field back through a combinational read port. A stop bit parked beside the seconds field freezes timekeeping. Any write to the seconds field sends a one-cycle request to the upstream divider so that it restarts its sub-second count.

Top module: `rtc_bcd_calendar`

## Requirements
- R1: Register layout by address: 0 = seconds in bits 6:0 with the stop bit in bit 7; 1 = minutes in bits 6:0; 2 = hours in bits 5:0, the century-flip enable in bit 7 and the century flag in bit 6; 3 = day of week in bits 2:0; 4 = day of month in bits 5:0; 5 = month in bits 4:0; 6 = year in bits 7:0. Bits outside these fields read 0. Address 7 reads 0x00, and writes to it change nothing.
- R2: Each accepted tick adds one second. Seconds go from 59 to 00 and carry into minutes. Minutes go from 59 to 00 and carry into hours. Hours go from 23 to 00. All fields are BCD.
- R3: When hours wrap from 23 to 00, day of week advances, going from 7 back to 1, and day of month advances.
- R4: The last day of a month is 31, or 30 for months 04, 06, 09 and 11. For month 02 it is 29 when the BCD year is a multiple of four (00 included) and 28 otherwise. After the last day, day of month returns to 01 and the month advances.
- R5: Month goes from 12 back to 01 and carries into the year. The year goes from 99 back to 00.
- R6: When the year wraps from 99 to 00 and the century-flip enable is 1, the century flag inverts. When the enable is 0, the flag holds.
- R7: While the stop bit is 1, ticks are ignored and no time field changes except by host writes.
- R8: After reset, seconds, minutes, hours and year are 00. Day of week, day of month and month are 01. The stop bit, the century-flip enable, the century flag and the divider-restart output are 0.
- R9: A host write to a field in the same cycle as an increment of that field wins. No carry passes from that field to the next field up in that cycle.
- R10: `div_rst_o` is high for exactly the one cycle after each write to address 0, whatever the data, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-second strobe, one cycle wide |
| wr_en_i | input | 1 | Host write strobe |
| wr_addr_i | input | 3 | Host write address |
| wr_data_i | input | 8 | Host write data |
| rd_addr_i | input | 3 | Read address |
| rd_data_o | output | 8 | Read data for `rd_addr_i` (combinational) |
| div_rst_o | output | 1 | Request to restart the sub-second divider |

## Verification
A host write and a tick-driven increment can hit the same field in the same cycle. The write must win, and the carry out of that field must stop there. The bench provokes this in two ways. Directed steps pair a tick with a seconds write and a tick with a minutes write while seconds sit at 59. Random steps pair ticks and writes freely, with time often preset near midnight and month end. A bench model applies writes after increments, field by field, and cuts carries at written fields. Every register is compared against it after every cycle.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  localparam int ADDR_W = 3;
  localparam int DATA_W = 8;

  localparam logic [ADDR_W-1:0] A_SEC  = 3'd0;
  localparam logic [ADDR_W-1:0] A_MIN  = 3'd1;
  localparam logic [ADDR_W-1:0] A_HOUR = 3'd2;
  localparam logic [ADDR_W-1:0] A_DOW  = 3'd3;
  localparam logic [ADDR_W-1:0] A_DATE = 3'd4;
  localparam logic [ADDR_W-1:0] A_MON  = 3'd5;
  localparam logic [ADDR_W-1:0] A_YEAR = 3'd6;

  localparam int SEC_W  = 7;
  localparam int MIN_W  = 7;
  localparam int HOUR_W = 6;
  localparam int DOW_W  = 4;
  localparam int DATE_W = 6;
  localparam int MON_W  = 5;
  localparam int YEAR_W = 8;

  // BCD year divisible by four: even tens need ones 0/4/8, odd tens need 2/6
  function automatic logic bcd_leap(input logic [7:0] yr);
    logic [3:0] ones;
    ones = yr[3:0];
    if (yr[4]) bcd_leap = (ones == 4'h2) || (ones == 4'h6);
    else       bcd_leap = (ones == 4'h0) || (ones == 4'h4) || (ones == 4'h8);
  endfunction

endpackage

// File: rtl/rtc_bcd_field.sv
module rtc_bcd_field #(
  parameter int           W  = 7,
  parameter logic [W-1:0] LO = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic [W-1:0] limit_i,
  output logic [W-1:0] val_o
);

  logic [W-1:0] val_q;
  logic [W-1:0] val_d;
  logic [W-1:0] stepped;
  logic         at_limit;

  // Wide fields count in two BCD digits; narrow fields are a single digit
  generate
    if (W > 4) begin : g_bcd
      always_comb begin
        if (val_q[3:0] == 4'h9) stepped = {val_q[W-1:4] + 1'b1, 4'h0};
        else                    stepped = {val_q[W-1:4], val_q[3:0] + 4'h1};
      end
    end else begin : g_bin
      always_comb stepped = val_q + 1'b1;
    end
  endgenerate

  assign at_limit = (val_q == limit_i);

  always_comb begin
    val_d = val_q;
    if (load_i)     val_d = load_val_i;
    else if (inc_i) val_d = at_limit ? LO : stepped;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) val_q <= LO;
    else        val_q <= val_d;
  end

  assign val_o = val_q;

  // R9
  load_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (val_o == $past(load_val_i)));

  // R2
  wrap_to_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !load_i && (val_o == limit_i)) |=> (val_o == LO));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc_i && !load_i) |=> $stable(val_o));

endmodule

// File: rtl/rtc_month_len.sv
module rtc_month_len
  import rtc_cal_pkg::*;
(
  input  logic [MON_W-1:0]  month_i,
  input  logic [YEAR_W-1:0] year_i,
  output logic [DATE_W-1:0] last_day_o
);

  always_comb begin
    case (month_i)
      5'h02:                      last_day_o = bcd_leap(year_i) ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: last_day_o = 6'h30;
      default:                    last_day_o = 6'h31;
    endcase
  end

endmodule

// File: rtl/rtc_bcd_calendar.sv
module rtc_bcd_calendar
  import rtc_cal_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              div_rst_o
);

  localparam int NFIELD = 7;

  logic [NFIELD-1:0] ld;
  logic [SEC_W-1:0]  sec;
  logic [MIN_W-1:0]  min;
  logic [HOUR_W-1:0] hour;
  logic [DOW_W-1:0]  dow;
  logic [DATE_W-1:0] date;
  logic [MON_W-1:0]  mon;
  logic [YEAR_W-1:0] year;
  logic [DATE_W-1:0] last_day;

  logic run_tick, sec_c, min_c, hour_c, date_c, mon_c, year_c;
  logic stop_q, stop_d, cen_q, cen_d, cent_q, cent_d, div_q, div_d;

  // Per-address write decode
  generate
    for (genvar k = 0; k < NFIELD; k++) begin : g_ld
      assign ld[k] = wr_en_i && (wr_addr_i == ADDR_W'(k));
    end
  endgenerate

  // Carry chain; a written field blocks the carry it would pass upward
  assign run_tick = tick_i && !stop_q;
  assign sec_c    = run_tick && !ld[A_SEC]  && (sec  == 7'h59);
  assign min_c    = sec_c    && !ld[A_MIN]  && (min  == 7'h59);
  assign hour_c   = min_c    && !ld[A_HOUR] && (hour == 6'h23);
  assign date_c   = hour_c   && !ld[A_DATE] && (date == last_day);
  assign mon_c    = date_c   && !ld[A_MON]  && (mon  == 5'h12);
  assign year_c   = mon_c    && !ld[A_YEAR] && (year == 8'h99);

  rtc_bcd_field #(.W(SEC_W), .LO(7'h00)) u_sec (
    .clk(clk), .rst_n(rst_n), .inc_i(run_tick), .load_i(ld[A_SEC]),
    .load_val_i(wr_data_i[SEC_W-1:0]), .limit_i(7'h59), .val_o(sec));

  rtc_bcd_field #(.W(MIN_W), .LO(7'h00)) u_min (
    .clk(clk), .rst_n(rst_n), .inc_i(sec_c), .load_i(ld[A_MIN]),
    .load_val_i(wr_data_i[MIN_W-1:0]), .limit_i(7'h59), .val_o(min));

  rtc_bcd_field #(.W(HOUR_W), .LO(6'h00)) u_hour (
    .clk(clk), .rst_n(rst_n), .inc_i(min_c), .load_i(ld[A_HOUR]),
    .load_val_i(wr_data_i[HOUR_W-1:0]), .limit_i(6'h23), .val_o(hour));

  rtc_bcd_field #(.W(DOW_W), .LO(4'h1)) u_dow (
    .clk(clk), .rst_n(rst_n), .inc_i(hour_c), .load_i(ld[A_DOW]),
    .load_val_i({1'b0, wr_data_i[2:0]}), .limit_i(4'h7), .val_o(dow));

  rtc_month_len u_len (
    .month_i(mon), .year_i(year), .last_day_o(last_day));

  rtc_bcd_field #(.W(DATE_W), .LO(6'h01)) u_date (
    .clk(clk), .rst_n(rst_n), .inc_i(hour_c), .load_i(ld[A_DATE]),
    .load_val_i(wr_data_i[DATE_W-1:0]), .limit_i(last_day), .val_o(date));

  rtc_bcd_field #(.W(MON_W), .LO(5'h01)) u_mon (
    .clk(clk), .rst_n(rst_n), .inc_i(date_c), .load_i(ld[A_MON]),
    .load_val_i(wr_data_i[MON_W-1:0]), .limit_i(5'h12), .val_o(mon));

  rtc_bcd_field #(.W(YEAR_W), .LO(8'h00)) u_year (
    .clk(clk), .rst_n(rst_n), .inc_i(mon_c), .load_i(ld[A_YEAR]),
    .load_val_i(wr_data_i), .limit_i(8'h99), .val_o(year));

  // Control bits next state
  always_comb begin
    stop_d = stop_q;
    cen_d  = cen_q;
    cent_d = cent_q;
    div_d  = ld[A_SEC];
    if (ld[A_SEC]) stop_d = wr_data_i[7];
    if (year_c && cen_q) cent_d = !cent_q;
    if (ld[A_HOUR]) begin
      cen_d  = wr_data_i[7];
      cent_d = wr_data_i[6];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_q <= 1'b0;
      cen_q  <= 1'b0;
      cent_q <= 1'b0;
      div_q  <= 1'b0;
    end else begin
      stop_q <= stop_d;
      cen_q  <= cen_d;
      cent_q <= cent_d;
      div_q  <= div_d;
    end
  end

  assign div_rst_o = div_q;

  // Read port
  always_comb begin
    case (rd_addr_i)
      A_SEC:   rd_data_o = {stop_q, sec};
      A_MIN:   rd_data_o = {1'b0, min};
      A_HOUR:  rd_data_o = {cen_q, cent_q, hour};
      A_DOW:   rd_data_o = {4'h0, dow};
      A_DATE:  rd_data_o = {2'b00, date};
      A_MON:   rd_data_o = {3'b000, mon};
      A_YEAR:  rd_data_o = year;
      default: rd_data_o = '0;
    endcase
  end

  // R7
  stop_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_q && !wr_en_i) |=> $stable(sec));

  // R6
  century_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cen_q && !ld[A_HOUR]) |=> $stable(cent_q));

  // R6
  century_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (year_c && cen_q && !ld[A_HOUR]) |=> (cent_q != $past(cent_q)));

  // R4
  date_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hour_c && !ld[A_DATE] && (date == last_day)) |=> (date == 6'h01));

endmodule

// File: tb/rtc_bcd_calendar_tb.sv
module rtc_bcd_calendar_tb;

  localparam int CLK_PERIOD = 20;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick;
  logic       wr_en;
  logic [2:0] wr_addr;
  logic [7:0] wr_data;
  logic [2:0] rd_addr;
  logic [7:0] rd_data;
  logic       div_rst;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // Reference model state, held in binary
  int ms, mm, mh, mw, md, mo, my;
  bit mstop, mce, mcb;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_bcd_calendar u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .div_rst_o(div_rst));

  function automatic logic [7:0] bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int unbcd(input logic [7:0] x);
    return int'(x[7:4]) * 10 + int'(x[3:0]);
  endfunction

  function automatic int days_in(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  function automatic logic [7:0] exp_reg(input int a);
    logic [7:0] b;
    case (a)
      0: begin b = bcd(ms); return {mstop, b[6:0]}; end
      1: begin b = bcd(mm); return {1'b0, b[6:0]}; end
      2: begin b = bcd(mh); return {mce, mcb, b[5:0]}; end
      3: return 8'(mw);
      4: begin b = bcd(md); return {2'b00, b[5:0]}; end
      5: begin b = bcd(mo); return {3'b000, b[4:0]}; end
      6: return bcd(my);
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // One cycle of the model: increments first, then writes override field by field
  task automatic model_step(input bit t, input bit we, input int a, input logic [7:0] d);
    int  f;
    bit  c, dc, yw;
    int  lim;
    f = we ? a : -1;
    c = t && !mstop;
    if (f == 0) begin ms = unbcd({1'b0, d[6:0]}); c = 0; end
    else if (c) begin if (ms == 59) ms = 0; else begin ms++; c = 0; end end
    if (f == 1) begin mm = unbcd({1'b0, d[6:0]}); c = 0; end
    else if (c) begin if (mm == 59) mm = 0; else begin mm++; c = 0; end end
    if (f == 2) begin mh = unbcd({2'b00, d[5:0]}); c = 0; end
    else if (c) begin if (mh == 23) mh = 0; else begin mh++; c = 0; end end
    dc = c;
    if (f == 3) mw = int'(d[2:0]);
    else if (dc) mw = (mw == 7) ? 1 : mw + 1;
    lim = days_in(mo, my);
    if (f == 4) begin md = unbcd({2'b00, d[5:0]}); c = 0; end
    else if (c) begin if (md == lim) md = 1; else begin md++; c = 0; end end
    if (f == 5) begin mo = unbcd({3'b000, d[4:0]}); c = 0; end
    else if (c) begin if (mo == 12) mo = 1; else begin mo++; c = 0; end end
    yw = 0;
    if (f == 6) begin my = unbcd(d); c = 0; end
    else if (c) begin if (my == 99) begin my = 0; yw = 1; end else my++; end
    if (yw && mce) mcb = !mcb;
    if (f == 2) begin mce = d[7]; mcb = d[6]; end
    if (f == 0) mstop = d[7];
  endtask

  task automatic compare_all(input string req);
    for (int a = 0; a < 8; a++) begin
      rd_addr = 3'(a);
      #1;
      chk(req, rd_data, exp_reg(a));
    end
  endtask

  task automatic cycle(input string req, input bit t, input bit we,
                       input int a, input logic [7:0] d);
    @(negedge clk);
    tick = t; wr_en = we; wr_addr = 3'(a); wr_data = d;
    @(posedge clk);
    #1;
    tick = 0; wr_en = 0;
    model_step(t, we, a, d);
    chk("R10", {7'b0, div_rst}, {7'b0, (we && a == 0)});
    compare_all(req);
  endtask

  task automatic set_all(input int h, input int mi, input int s, input int w,
                         input int dd, input int mon, input int y,
                         input bit ce, input bit cb);
    cycle("R1", 0, 1, 6, bcd(y));
    cycle("R1", 0, 1, 5, bcd(mon));
    cycle("R1", 0, 1, 4, bcd(dd));
    cycle("R1", 0, 1, 3, bcd(w));
    cycle("R1", 0, 1, 2, {ce, cb, 6'(bcd(h))});
    cycle("R1", 0, 1, 1, bcd(mi));
    cycle("R1", 0, 1, 0, bcd(s));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'd7341;
    void'($urandom(seed));
    rst_n = 0; tick = 0; wr_en = 0; wr_addr = 0; wr_data = 0; rd_addr = 0;
    ms = 0; mm = 0; mh = 0; mw = 1; md = 1; mo = 1; my = 0;
    mstop = 0; mce = 0; mcb = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R8", {7'b0, div_rst}, 8'h00);
    compare_all("R8");

    // R2: plain seconds, then minute and hour carry
    repeat (3) cycle("R2", 1, 0, 0, 8'h00);
    set_all(0, 59, 58, 2, 10, 3, 24, 0, 0);
    repeat (2) cycle("R2", 1, 0, 0, 8'h00);
    rd_addr = 3'd2; #1; chk("R2", rd_data, 8'h01);

    // R3 R5 R6: full wrap with century flip enabled
    set_all(23, 59, 59, 7, 31, 12, 99, 1, 0);
    cycle("R5", 1, 0, 0, 8'h00);
    rd_addr = 3'd2; #1; chk("R6", rd_data, 8'hC0);
    rd_addr = 3'd3; #1; chk("R3", rd_data, 8'h01);
    rd_addr = 3'd6; #1; chk("R5", rd_data, 8'h00);
    // R6: flip disabled, flag holds
    set_all(23, 59, 59, 5, 31, 12, 99, 0, 1);
    cycle("R6", 1, 0, 0, 8'h00);
    rd_addr = 3'd2; #1; chk("R6", rd_data, 8'h40);

    // R4: month lengths and leap years
    set_all(23, 59, 59, 1, 28, 2, 0, 0, 0);
    cycle("R4", 1, 0, 0, 8'h00);
    rd_addr = 3'd4; #1; chk("R4", rd_data, 8'h29);
    set_all(23, 59, 59, 1, 29, 2, 0, 0, 0);
    cycle("R4", 1, 0, 0, 8'h00);
    rd_addr = 3'd5; #1; chk("R4", rd_data, 8'h03);
    set_all(23, 59, 59, 1, 28, 2, 1, 0, 0);
    cycle("R4", 1, 0, 0, 8'h00);
    set_all(23, 59, 59, 1, 28, 2, 12, 0, 0);
    cycle("R4", 1, 0, 0, 8'h00);
    set_all(23, 59, 59, 1, 28, 2, 10, 0, 0);
    cycle("R4", 1, 0, 0, 8'h00);
    set_all(23, 59, 59, 1, 30, 4, 10, 0, 0);
    cycle("R4", 1, 0, 0, 8'h00);
    set_all(23, 59, 59, 1, 30, 1, 10, 0, 0);
    cycle("R4", 1, 0, 0, 8'h00);
    cycle("R4", 0, 0, 0, 8'h00);

    // R7: stop bit freezes time
    cycle("R7", 0, 1, 0, 8'hB0);
    repeat (5) cycle("R7", 1, 0, 0, 8'h00);
    rd_addr = 3'd0; #1; chk("R7", rd_data, 8'hB0);
    cycle("R7", 0, 1, 0, 8'h30);
    cycle("R7", 1, 0, 0, 8'h00);
    rd_addr = 3'd0; #1; chk("R7", rd_data, 8'h31);

    // R9: write beats a same-cycle increment, carry stops there
    set_all(5, 20, 59, 3, 12, 6, 40, 0, 0);
    cycle("R9", 1, 1, 1, 8'h10);
    rd_addr = 3'd1; #1; chk("R9", rd_data, 8'h10);
    rd_addr = 3'd0; #1; chk("R9", rd_data, 8'h00);
    cycle("R9", 1, 1, 0, 8'h20);
    rd_addr = 3'd0; #1; chk("R9", rd_data, 8'h20);

    // R1: address 7 ignores writes
    cycle("R1", 0, 1, 7, 8'hFF);
    cycle("R1", 1, 1, 7, 8'h5A);

    // Random mix of ticks and writes
    for (int i = 0; i < 2500; i++) begin
      bit t, we;
      int a;
      logic [7:0] d;
      t = ($urandom % 8) != 0;
      we = ($urandom % 4) == 0;
      a = 0; d = 8'h00;
      if (we) begin
        a = $urandom % 8;
        case (a)
          0: d = {(($urandom % 16) == 0), 7'(bcd(50 + $urandom % 10))};
          1: d = bcd(($urandom % 2) ? 59 : $urandom % 60);
          2: d = {1'($urandom), 1'($urandom), 6'(bcd(($urandom % 2) ? 23 : $urandom % 24))};
          3: d = bcd(1 + $urandom % 7);
          4: d = bcd(days_in(mo, my) - ($urandom % 3));
          5: if (md <= 28) d = bcd(1 + $urandom % 12); else we = 0;
          6: if (!(mo == 2 && md == 29)) d = bcd(($urandom % 2) ? 99 : $urandom % 100);
             else we = 0;
          default: d = 8'($urandom);
        endcase
      end
      cycle("R9", t, we, a, d);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule